// File: doc/BRIEF.md
# D-PHY Test-Port Write Sequencer

This block programs the internal configuration registers of a D-PHY through the PHY's serial test-control port. A host writes register-address/value byte pairs into a small first-in, first-out queue. The block takes one pair at a time and drives the test clock, the test-enable line and the shared 8-bit test data bus. The PHY captures the address on the falling clock edge and the value on the next rising edge.

A host may also request a PHY clear. The block then produces a low-high-low pulse on the clear line. A pending clear runs before any queued pair that is waiting. Every waveform step lasts a programmable number of system clocks. Handshake outputs report activity, queue fullness and emptiness, and a sticky overflow flag.

Top module: `dphy_test_port_seq`

## Requirements
- R1: After reset, tst_clk is 1, tst_en is 0, tst_din is 0, tst_clr is 0, busy is 0 and q_empty is 1.
- R2: Each pair starts with tst_clk high and tst_clr low, then raises tst_en with the code on tst_din, then drops tst_clk; at that falling edge tst_en is 1 and tst_din holds the code.
- R3: tst_en then falls with the data on tst_din, then tst_clk rises; at that rising edge tst_en is 0 and tst_din holds the data.
- R4: tst_en rises only while tst_clk is high and falls only while tst_clk is low.
- R5: Every step lasts N system clocks, where N is half_period sampled at the start of the step, and a value of 0 counts as 1. The tst_clk falling edge is followed by the rising edge exactly 2N clocks later.
- R6: Pairs are sent in exactly the order they were accepted.
- R7: A clr_req pulse produces tst_clr low for one step, high for one step and low for one step, so tst_clr is high for N clocks. tst_clr is never high while tst_en is high or tst_clk is low.
- R8: When a clear request and queued pairs are both waiting, the clear sequence runs first.
- R9: busy is high from the first step of a pair until the final tst_clk rising edge has been held for N clocks, and it falls exactly N clocks after that edge. tst_clk is never low while busy is low.
- R10: A push while the queue is full is dropped and sets ovf, which stays set until ovf_clr is pulsed. If both happen in the same cycle, setting wins.
- R11: q_full is 1 when the queue holds DEPTH pairs and q_empty is 1 when it holds none. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Write one pair into the queue |
| push_code | input | 8 | Register address to send |
| push_data | input | 8 | Register value to send |
| clr_req | input | 1 | Request a PHY clear pulse |
| ovf_clr | input | 1 | Clear the overflow flag |
| half_period | input | HP_W | Step length in clocks (0 counts as 1) |
| tst_clk | output | 1 | Test clock to PHY |
| tst_en | output | 1 | Test enable to PHY |
| tst_din | output | 8 | Test data bus to PHY |
| tst_clr | output | 1 | Test clear to PHY, active high |
| busy | output | 1 | A pair or clear sequence is in progress |
| q_empty | output | 1 | Queue holds no pairs |
| q_full | output | 1 | Queue holds DEPTH pairs |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with DEPTH=4 and HP_W=4. Because the queue is shallow, a clear sequence with a long step of 15 clocks holds the queue long enough to fill it and push past full. Step lengths of 0, 1, 2 and 3 bring the degenerate single-clock step and the 2N edge spacing within reach of short random bursts. A push issued in the same cycle as a clear request exercises the priority of a waiting clear over a waiting pair.

// File: rtl/dphy_tp_pkg.sv
package dphy_tp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_CODE,
    ST_FALL,
    ST_DATA,
    ST_RISE,
    ST_CLR_LO0,
    ST_CLR_HI,
    ST_CLR_LO1
  } step_t;

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] data;
  } pair_t;

  localparam int PAIR_W = $bits(pair_t);
endpackage

// File: rtl/dtp_fifo.sv
module dtp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == FULLC);
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
    if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dtp_step_timer.sv
module dtp_step_timer #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HP_W-1:0] len,
  output logic            done
);
  logic [HP_W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - 1'b1;
    end else if (!done) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dtp_ovf_flag.sv
module dtp_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic full,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)              flag <= 1'b0;
    else if (push && full) flag <= 1'b1;
    else if (clr)         flag <= 1'b0;
  end
endmodule

// File: rtl/dtp_seq.sv
module dtp_seq
  import dphy_tp_pkg::*;
#(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_req,
  input  logic            q_empty,
  input  pair_t           cur,
  input  logic [HP_W-1:0] half_period,
  output logic            pop,
  output logic            tst_clk,
  output logic            tst_en,
  output logic [7:0]      tst_din,
  output logic            tst_clr,
  output logic            busy
);
  step_t st;
  logic  pend, done, load, take_clr;

  assign take_clr = (st == ST_IDLE) && pend;
  assign pop      = (st == ST_IDLE) && !pend && !q_empty;
  assign load     = take_clr || pop ||
                    ((st != ST_IDLE) && done && (st != ST_RISE) && (st != ST_CLR_LO1));
  assign busy     = (st != ST_IDLE);

  dtp_step_timer #(.HP_W(HP_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .len  (half_period),
    .done (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pend    <= 1'b0;
      tst_clk <= 1'b1;
      tst_en  <= 1'b0;
      tst_din <= '0;
      tst_clr <= 1'b0;
    end else begin
      pend <= clr_req || (pend && !take_clr);
      case (st)
        ST_IDLE: begin
          if (take_clr) begin
            st      <= ST_CLR_LO0;
            tst_clr <= 1'b0;
          end else if (pop) begin
            st      <= ST_PRE;
            tst_clk <= 1'b1;
            tst_clr <= 1'b0;
          end
        end
        ST_PRE: if (done) begin
          st      <= ST_CODE;
          tst_en  <= 1'b1;
          tst_din <= cur.code;
        end
        ST_CODE: if (done) begin
          st      <= ST_FALL;
          tst_clk <= 1'b0;
        end
        ST_FALL: if (done) begin
          st      <= ST_DATA;
          tst_en  <= 1'b0;
          tst_din <= cur.data;
        end
        ST_DATA: if (done) begin
          st      <= ST_RISE;
          tst_clk <= 1'b1;
        end
        ST_RISE: if (done) st <= ST_IDLE;
        ST_CLR_LO0: if (done) begin
          st      <= ST_CLR_HI;
          tst_clr <= 1'b1;
        end
        ST_CLR_HI: if (done) begin
          st      <= ST_CLR_LO1;
          tst_clr <= 1'b0;
        end
        ST_CLR_LO1: if (done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dphy_test_port_seq.sv
module dphy_test_port_seq
  import dphy_tp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HP_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_vld,
  input  logic [7:0]      push_code,
  input  logic [7:0]      push_data,
  input  logic            clr_req,
  input  logic            ovf_clr,
  input  logic [HP_W-1:0] half_period,
  output logic            tst_clk,
  output logic            tst_en,
  output logic [7:0]      tst_din,
  output logic            tst_clr,
  output logic            busy,
  output logic            q_empty,
  output logic            q_full,
  output logic            ovf
);
  pair_t         wr_pair, rd_pair;
  logic [PAIR_W-1:0] rd_bits;
  logic          pop;

  assign wr_pair = '{code: push_code, data: push_data};
  assign rd_pair = pair_t'(rd_bits);

  dtp_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push_vld),
    .wr_data (wr_pair),
    .rd_en   (pop),
    .rd_data (rd_bits),
    .full    (q_full),
    .empty   (q_empty)
  );

  dtp_ovf_flag u_ovf (
    .clk  (clk),
    .rst  (rst),
    .push (push_vld),
    .full (q_full),
    .clr  (ovf_clr),
    .flag (ovf)
  );

  dtp_seq #(.HP_W(HP_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .clr_req     (clr_req),
    .q_empty     (q_empty),
    .cur         (rd_pair),
    .half_period (half_period),
    .pop         (pop),
    .tst_clk     (tst_clk),
    .tst_en      (tst_en),
    .tst_din     (tst_din),
    .tst_clr     (tst_clr),
    .busy        (busy)
  );
endmodule

// File: rtl/dtp_checker.sv
module dtp_checker (
  input logic       clk,
  input logic       rst,
  input logic       push_vld,
  input logic       tst_clk,
  input logic       tst_en,
  input logic [7:0] tst_din,
  input logic       tst_clr,
  input logic       busy,
  input logic       q_empty,
  input logic       q_full,
  input logic       ovf
);
  // R1
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (tst_clk && !tst_en && tst_din == 8'd0 && !tst_clr && !busy && q_empty));

  // R2
  code_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tst_clk) |-> (tst_en && $stable(tst_din)));

  // R3
  data_prog_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tst_clk) |-> (!tst_en && $stable(tst_din)));

  // R4
  en_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tst_en) |-> tst_clk);

  // R4
  en_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tst_en) |-> !tst_clk);

  // R7
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tst_clr |-> (tst_clk && !tst_en));

  // R9
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tst_clk);

  // R10
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(push_vld && q_full));

  // R11
  full_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));
endmodule

bind dphy_test_port_seq dtp_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .push_vld (push_vld),
  .tst_clk  (tst_clk),
  .tst_en   (tst_en),
  .tst_din  (tst_din),
  .tst_clr  (tst_clr),
  .busy     (busy),
  .q_empty  (q_empty),
  .q_full   (q_full),
  .ovf      (ovf)
);

// File: tb/dphy_test_port_seq_test.sv
`timescale 1ns/1ps
module dphy_test_port_seq_test;
  localparam int DEPTH = 4;
  localparam int HP_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_vld = 1'b0;
  logic [7:0] push_code = '0, push_data = '0;
  logic clr_req = 1'b0, ovf_clr = 1'b0;
  logic [HP_W-1:0] half_period = '0;
  logic tst_clk, tst_en, tst_clr, busy, q_empty, q_full, ovf;
  logic [7:0] tst_din;

  dphy_test_port_seq #(.DEPTH(DEPTH), .HP_W(HP_W)) uut (
    .clk(clk), .rst(rst), .push_vld(push_vld), .push_code(push_code),
    .push_data(push_data), .clr_req(clr_req), .ovf_clr(ovf_clr),
    .half_period(half_period), .tst_clk(tst_clk), .tst_en(tst_en),
    .tst_din(tst_din), .tst_clr(tst_clr), .busy(busy), .q_empty(q_empty),
    .q_full(q_full), .ovf(ovf)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  logic [7:0] exp_code [64];
  logic [7:0] exp_data [64];
  int wr_i = 0, rd_i = 0;
  int cur_n = 1;
  int tf = 0, tr = 0, tcr = 0;
  logic want_busy = 1'b0;
  logic pclk = 1'b1, pclr = 1'b0;
  int clr_rise_pairs = -1;
  int pairs_in_clear = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int step_len(input int hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  // Pin monitor: reconstructs pairs and edge spacing from the port waveform
  always @(negedge clk) begin
    if (!rst) begin
      if (pclk && !tst_clk) begin
        tf = cyc;
        if (tst_clr) pairs_in_clear++;
        check(rd_i < wr_i, "R6 unexpected pair", rd_i, wr_i);
        check(tst_en == 1'b1, "R2 tst_en at fall", int'(tst_en), 1);
        check(tst_din == exp_code[rd_i % 64], "R2 code at fall", int'(tst_din), int'(exp_code[rd_i % 64]));
      end
      if (!pclk && tst_clk) begin
        tr = cyc;
        check(tst_en == 1'b0, "R3 tst_en at rise", int'(tst_en), 0);
        check(tst_din == exp_data[rd_i % 64], "R3/R6 data at rise", int'(tst_din), int'(exp_data[rd_i % 64]));
        check(tr - tf == 2 * cur_n, "R5 fall-to-rise spacing", tr - tf, 2 * cur_n);
        rd_i++;
        want_busy = 1'b1;
      end
      if (want_busy && !busy) begin
        check(cyc - tr == cur_n, "R9 busy hold after rise", cyc - tr, cur_n);
        want_busy = 1'b0;
      end
      if (!pclr && tst_clr) begin
        tcr = cyc;
        clr_rise_pairs = rd_i;
      end
      if (pclr && !tst_clr)
        check(cyc - tcr == cur_n, "R7 clear pulse width", cyc - tcr, cur_n);
      pclk = tst_clk;
      pclr = tst_clr;
    end
  end

  task automatic push(input logic [7:0] c, input logic [7:0] d, input bit accept);
    @(negedge clk);
    push_vld = 1'b1; push_code = c; push_data = d;
    if (accept) begin
      exp_code[wr_i % 64] = c;
      exp_data[wr_i % 64] = d;
      wr_i++;
    end
    @(negedge clk);
    push_vld = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while ((busy || !q_empty || rd_i != wr_i || want_busy) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tst_clk == 1'b1 && tst_en == 1'b0 && tst_din == 8'h00, "R1 pins after reset",
          int'({tst_clk, tst_en, tst_din}), 512);
    check(tst_clr == 1'b0 && busy == 1'b0, "R1 clr/busy after reset", int'({tst_clr, busy}), 0);
    check(q_empty == 1'b1 && q_full == 1'b0, "R1/R11 queue empty after reset", int'({q_empty, q_full}), 2);

    // Directed: single pair, N=2
    half_period = 4'd2; cur_n = step_len(2);
    push(8'h5a, 8'hc3, 1'b1);
    wait_idle();
    check(rd_i == 1, "R6 single pair sent", rd_i, 1);

    // Directed: half_period 0 acts as 1
    half_period = 4'd0; cur_n = step_len(0);
    push(8'h01, 8'hfe, 1'b1);
    push(8'h80, 8'h7f, 1'b1);
    wait_idle();

    // R8: clear and a push in the same cycle, clear goes first
    half_period = 4'd3; cur_n = step_len(3);
    @(negedge clk);
    clr_req = 1'b1; push_vld = 1'b1; push_code = 8'h44; push_data = 8'h22;
    exp_code[wr_i % 64] = 8'h44; exp_data[wr_i % 64] = 8'h22; wr_i++;
    @(negedge clk);
    clr_req = 1'b0; push_vld = 1'b0;
    wait_idle();
    check(clr_rise_pairs == wr_i - 1, "R8 clear before queued pair", clr_rise_pairs, wr_i - 1);

    // R10/R11: long clear holds the queue, fill and overflow it
    half_period = 4'd15; cur_n = step_len(15);
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < DEPTH; k++) push(8'h10 + 8'(k), 8'ha0 + 8'(k), 1'b1);
    check(q_full == 1'b1 && q_empty == 1'b0, "R11 queue full after DEPTH pushes", int'({q_full, q_empty}), 2);
    check(ovf == 1'b0, "R10 no overflow before full push", int'(ovf), 0);
    push(8'hee, 8'hdd, 1'b0);
    check(ovf == 1'b1, "R10 overflow set by push into full", int'(ovf), 1);
    wait_idle();
    check(pairs_in_clear == 0, "R7 no pair during clear", pairs_in_clear, 0);
    check(rd_i == wr_i, "R10 dropped pair never sent", rd_i, wr_i);
    check(ovf == 1'b1, "R10 overflow sticky", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(ovf == 1'b0, "R10 overflow cleared", int'(ovf), 0);
    check(q_empty == 1'b1, "R11 queue empty after drain", int'(q_empty), 1);

    // Random bursts
    for (int b = 0; b < 40; b++) begin
      int hp, n;
      hp = int'($urandom_range(0, 3));
      half_period = 4'(hp); cur_n = step_len(hp);
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < n; k++)
        push(8'($urandom), 8'($urandom), 1'b1);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
      end
      wait_idle();
    end
    check(rd_i == wr_i, "R6 all random pairs sent in order", rd_i, wr_i);
    check(tst_clk == 1'b1 && tst_en == 1'b0 && busy == 1'b0, "R9 idle pins", int'({tst_clk, tst_en, busy}), 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule